// File: doc/BRIEF.md
# Dual-Channel Sample Code Formatter

This block is the digital back end of a two-channel sampling converter. Every rising clock edge it takes a raw 10-bit offset-binary code and an over-range flag from each of two channels. It carries each channel through a fixed six-cycle pipeline. On the way out it clamps over-range samples to full scale and writes each code as offset binary or as two's complement. It then steers the channels onto two output ports, either straight through or crossed over.

Each port has an active-low enable and a valid flag. Each channel has an active-high power-down input. Power-down empties that channel's pipeline, so valid data returns only after the pipeline has refilled. A system can toggle the port steering select on every cycle to alternate both channels onto a single port at twice the rate of either channel.

Top module: `dual_conv_fmt`

## Requirements
- R1: A sample taken at a rising edge appears on the port data and over-range outputs after the sixth rising edge, counting the capture edge as the first. In offset-binary mode the code is passed through unchanged.
- R2: When `fmt_twos` is high at an edge, the code that leaves at that edge has its MSB (bit 9) inverted, which gives two's complement. When `fmt_twos` is low the code is offset binary. The select takes effect one edge after it is applied.
- R3: When `route_sel` is high at an edge, port A takes channel A and port B takes channel B. When it is low, port A takes channel B and port B takes channel A.
- R4: If `route_sel` toggles every cycle, each port alternates between the two channels edge by edge. Each port then shows, in turn, both channels' six-cycle-delayed samples.
- R5: A sample whose over-range flag is set leaves as positive full scale if its raw MSB is 1, and as negative full scale if its raw MSB is 0. In offset binary these are 0x3FF and 0x000; in two's complement they are 0x1FF and 0x200. The port over-range output is high for that same sample.
- R6: When a port's active-low enable is high at an edge, that port's data, over-range and valid outputs are zero after that edge.
- R7: While a channel's power-down input is high, every port carrying that channel shows zero data, zero over-range and a low valid flag after each edge. The channel's pipeline is emptied. Valid goes high again only for samples captured after power-down falls, and the first of these appears six edges after capture.
- R8: While the synchronous reset is high, all port outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; both channels capture on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_code | input | 10 | Raw offset-binary code, channel A |
| a_otr | input | 1 | Raw over-range flag, channel A |
| b_code | input | 10 | Raw offset-binary code, channel B |
| b_otr | input | 1 | Raw over-range flag, channel B |
| pd_a | input | 1 | Power-down for channel A, active high |
| pd_b | input | 1 | Power-down for channel B, active high |
| fmt_twos | input | 1 | 0 = offset binary, 1 = two's complement |
| route_sel | input | 1 | 1 = straight steering, 0 = crossed steering |
| oe_a_n | input | 1 | Port A enable, active low |
| oe_b_n | input | 1 | Port B enable, active low |
| pa_data | output | 10 | Port A code |
| pa_otr | output | 1 | Port A over-range |
| pa_vld | output | 1 | Port A data valid |
| pb_data | output | 10 | Port B code |
| pb_otr | output | 1 | Port B over-range |
| pb_vld | output | 1 | Port B data valid |

## Verification
The per-sample path is due six edges after capture. The format, steering, enable and power-down controls act only at the final register, so their effect is due one edge after they are applied. For each edge, the driver computes what each port must show from the raw samples it drove five edges earlier, the power-down history since then, and the controls at that edge. It queues this expectation before the edge. The monitor pops the queue on the following falling edge, after the output register has settled, and compares.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic { FMT_OFFSET = 1'b0, FMT_TWOS = 1'b1 } code_fmt_e;
  typedef enum logic { ROUTE_CROSS = 1'b0, ROUTE_STRAIGHT = 1'b1 } route_e;
endpackage

// File: rtl/dcf_chan_pipe.sv
// Capture register plus delay stages for one channel. Power-down empties it.
module dcf_chan_pipe #(
  parameter int W   = 10,
  parameter int LAT = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pd,
  input  logic [W-1:0] raw_code,
  input  logic         raw_otr,
  output logic [W-1:0] d_code,
  output logic         d_otr,
  output logic         d_vld
);
  // the port output register supplies the last cycle of latency
  localparam int DEPTH = LAT - 1;

  logic [W-1:0] code_q [DEPTH];
  logic         otr_q  [DEPTH];
  logic         vld_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      for (int i = 0; i < DEPTH; i++) begin
        code_q[i] <= '0;
        otr_q[i]  <= 1'b0;
        vld_q[i]  <= 1'b0;
      end
    end else begin
      code_q[0] <= raw_code;
      otr_q[0]  <= raw_otr;
      vld_q[0]  <= 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
        code_q[i] <= code_q[i-1];
        otr_q[i]  <= otr_q[i-1];
        vld_q[i]  <= vld_q[i-1];
      end
    end
  end

  assign d_code = code_q[DEPTH-1];
  assign d_otr  = otr_q[DEPTH-1];
  assign d_vld  = vld_q[DEPTH-1];
endmodule

// File: rtl/dcf_code_fmt.sv
// Over-range clamp followed by output format conversion.
module dcf_code_fmt #(
  parameter int W = 10
) (
  input  logic         [W-1:0] code_in,
  input  logic                 otr_in,
  input  dcf_pkg::code_fmt_e   fmt,
  output logic         [W-1:0] code_out
);
  logic [W-1:0] clamped;

  always_comb begin
    // raw MSB tells which end of the range was exceeded
    clamped  = otr_in ? {W{code_in[W-1]}} : code_in;
    code_out = clamped;
    if (fmt == dcf_pkg::FMT_TWOS) code_out[W-1] = ~clamped[W-1];
  end
endmodule

// File: rtl/dcf_port.sv
// One output port: channel pick, format, gating and output register.
module dcf_port #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_own,
  input  logic         fmt_twos,
  input  logic         oe_n,
  input  logic [W-1:0] own_code,
  input  logic         own_otr,
  input  logic         own_vld,
  input  logic         own_pd,
  input  logic [W-1:0] oth_code,
  input  logic         oth_otr,
  input  logic         oth_vld,
  input  logic         oth_pd,
  output logic [W-1:0] q_code,
  output logic         q_otr,
  output logic         q_vld
);
  logic [W-1:0] sel_code, fmt_code;
  logic         sel_otr, sel_vld, sel_pd, live;
  dcf_pkg::code_fmt_e fmt;

  always_comb begin
    sel_code = take_own ? own_code : oth_code;
    sel_otr  = take_own ? own_otr  : oth_otr;
    sel_vld  = take_own ? own_vld  : oth_vld;
    sel_pd   = take_own ? own_pd   : oth_pd;
    fmt      = fmt_twos ? dcf_pkg::FMT_TWOS : dcf_pkg::FMT_OFFSET;
    live     = sel_vld & ~sel_pd & ~oe_n;
  end

  dcf_code_fmt #(.W(W)) u_fmt (
    .code_in (sel_code),
    .otr_in  (sel_otr),
    .fmt     (fmt),
    .code_out(fmt_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_code <= '0;
      q_otr  <= 1'b0;
      q_vld  <= 1'b0;
    end else begin
      q_code <= live ? fmt_code : '0;
      q_otr  <= live & sel_otr;
      q_vld  <= live;
    end
  end
endmodule

// File: rtl/dual_conv_fmt.sv
module dual_conv_fmt #(
  parameter int W   = 10,
  parameter int LAT = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_code,
  input  logic         a_otr,
  input  logic [W-1:0] b_code,
  input  logic         b_otr,
  input  logic         pd_a,
  input  logic         pd_b,
  input  logic         fmt_twos,
  input  logic         route_sel,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  output logic [W-1:0] pa_data,
  output logic         pa_otr,
  output logic         pa_vld,
  output logic [W-1:0] pb_data,
  output logic         pb_otr,
  output logic         pb_vld
);
  localparam int NCH = 2;

  logic [W-1:0] raw_c [NCH];
  logic         raw_o [NCH];
  logic         pd_v  [NCH];
  logic         oe_v  [NCH];
  logic [W-1:0] dl_c  [NCH];
  logic         dl_o  [NCH];
  logic         dl_v  [NCH];
  logic [W-1:0] pq_c  [NCH];
  logic         pq_o  [NCH];
  logic         pq_v  [NCH];

  always_comb begin
    raw_c[0] = a_code; raw_o[0] = a_otr; pd_v[0] = pd_a; oe_v[0] = oe_a_n;
    raw_c[1] = b_code; raw_o[1] = b_otr; pd_v[1] = pd_b; oe_v[1] = oe_b_n;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int OTH = NCH - 1 - g;

    dcf_chan_pipe #(.W(W), .LAT(LAT)) u_pipe (
      .clk     (clk),
      .rst     (rst),
      .pd      (pd_v[g]),
      .raw_code(raw_c[g]),
      .raw_otr (raw_o[g]),
      .d_code  (dl_c[g]),
      .d_otr   (dl_o[g]),
      .d_vld   (dl_v[g])
    );

    dcf_port #(.W(W)) u_port (
      .clk     (clk),
      .rst     (rst),
      .take_own(route_sel),
      .fmt_twos(fmt_twos),
      .oe_n    (oe_v[g]),
      .own_code(dl_c[g]),
      .own_otr (dl_o[g]),
      .own_vld (dl_v[g]),
      .own_pd  (pd_v[g]),
      .oth_code(dl_c[OTH]),
      .oth_otr (dl_o[OTH]),
      .oth_vld (dl_v[OTH]),
      .oth_pd  (pd_v[OTH]),
      .q_code  (pq_c[g]),
      .q_otr   (pq_o[g]),
      .q_vld   (pq_v[g])
    );
  end

  assign pa_data = pq_c[0];
  assign pa_otr  = pq_o[0];
  assign pa_vld  = pq_v[0];
  assign pb_data = pq_c[1];
  assign pb_otr  = pq_o[1];
  assign pb_vld  = pq_v[1];
endmodule

// File: rtl/dual_conv_fmt_chk.sv
module dual_conv_fmt_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         pd_a,
  input logic         pd_b,
  input logic         route_sel,
  input logic         oe_a_n,
  input logic         oe_b_n,
  input logic [W-1:0] pa_data,
  input logic         pa_otr,
  input logic         pa_vld,
  input logic [W-1:0] pb_data,
  input logic         pb_otr,
  input logic         pb_vld
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};
  localparam logic [W-1:0] ALL0 = {W{1'b0}};
  localparam logic [W-1:0] MID1 = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MID0 = {1'b0, {(W-1){1'b1}}};

  assert_reset_zero_R8: assert property (@(posedge clk)
    $past(rst) |-> (pa_data == ALL0 && !pa_otr && !pa_vld && pb_data == ALL0 && !pb_otr && !pb_vld));

  assert_oe_a_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(oe_a_n)) |-> (pa_data == ALL0 && !pa_otr && !pa_vld));

  assert_oe_b_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(oe_b_n)) |-> (pb_data == ALL0 && !pb_otr && !pb_vld));

  assert_pd_port_a_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (($past(route_sel) && $past(pd_a)) || (!$past(route_sel) && $past(pd_b))))
      |-> (!pa_vld && pa_data == ALL0));

  assert_pd_port_b_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (($past(route_sel) && $past(pd_b)) || (!$past(route_sel) && $past(pd_a))))
      |-> (!pb_vld && pb_data == ALL0));

  assert_invalid_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!pa_vld |-> (pa_data == ALL0 && !pa_otr)) and (!pb_vld |-> (pb_data == ALL0 && !pb_otr)));

  assert_clamp_a_R5: assert property (@(posedge clk) disable iff (rst)
    pa_otr |-> (pa_data == ALL1 || pa_data == ALL0 || pa_data == MID1 || pa_data == MID0));

  assert_clamp_b_R5: assert property (@(posedge clk) disable iff (rst)
    pb_otr |-> (pb_data == ALL1 || pb_data == ALL0 || pb_data == MID1 || pb_data == MID0));
endmodule

bind dual_conv_fmt dual_conv_fmt_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .pd_a(pd_a), .pd_b(pd_b), .route_sel(route_sel),
  .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
  .pa_data(pa_data), .pa_otr(pa_otr), .pa_vld(pa_vld),
  .pb_data(pb_data), .pb_otr(pb_otr), .pb_vld(pb_vld)
);

// File: tb/dual_conv_fmt_bench.sv
module dual_conv_fmt_bench;
  localparam int W = 10;
  localparam int LAT = 6;
  localparam int HMAX = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_code = '0, b_code = '0;
  logic a_otr = 1'b0, b_otr = 1'b0, pd_a = 1'b0, pd_b = 1'b0;
  logic fmt_twos = 1'b0, route_sel = 1'b1, oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic [W-1:0] pa_data, pb_data;
  logic pa_otr, pa_vld, pb_otr, pb_vld;

  always #2.5 clk = ~clk;

  dual_conv_fmt #(.W(W), .LAT(LAT)) u_dual_conv_fmt (
    .clk(clk), .rst(rst), .a_code(a_code), .a_otr(a_otr), .b_code(b_code), .b_otr(b_otr),
    .pd_a(pd_a), .pd_b(pd_b), .fmt_twos(fmt_twos), .route_sel(route_sel),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .pa_data(pa_data), .pa_otr(pa_otr), .pa_vld(pa_vld),
    .pb_data(pb_data), .pb_otr(pb_otr), .pb_vld(pb_vld)
  );

  typedef struct {
    logic [W-1:0] d [2];
    logic         o [2];
    logic         v [2];
    string        tag [2];
  } exp_t;

  exp_t q [$];
  int checks = 0, errors = 0, n = 0;
  logic [W-1:0] hc [2][HMAX];
  logic         ho [2][HMAX];
  logic         hp [2][HMAX];

  // Monitor: one falling edge after each rising edge, compare both ports
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pa_data !== e.d[0] || pa_otr !== e.o[0] || pa_vld !== e.v[0]) begin
        errors++;
        $display("FAIL %s port A: got data=%h otr=%b vld=%b expected data=%h otr=%b vld=%b",
                 e.tag[0], pa_data, pa_otr, pa_vld, e.d[0], e.o[0], e.v[0]);
      end
      checks++;
      if (pb_data !== e.d[1] || pb_otr !== e.o[1] || pb_vld !== e.v[1]) begin
        errors++;
        $display("FAIL %s port B: got data=%h otr=%b vld=%b expected data=%h otr=%b vld=%b",
                 e.tag[1], pb_data, pb_otr, pb_vld, e.d[1], e.o[1], e.v[1]);
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue what the ports show after that edge
  task automatic step(input logic [W-1:0] ra, input logic oa, input logic [W-1:0] rb, input logic ob,
                      input logic pda, input logic pdb, input logic fmt, input logic route,
                      input logic oea, input logic oeb, input bit inter);
    exp_t e;
    logic oe [2];
    @(negedge clk); #1;
    rst = 1'b0;
    a_code = ra; a_otr = oa; b_code = rb; b_otr = ob;
    pd_a = pda; pd_b = pdb; fmt_twos = fmt; route_sel = route; oe_a_n = oea; oe_b_n = oeb;
    hc[0][n] = ra; ho[0][n] = oa; hp[0][n] = pda;
    hc[1][n] = rb; ho[1][n] = ob; hp[1][n] = pdb;
    oe[0] = oea; oe[1] = oeb;
    for (int p = 0; p < 2; p++) begin
      int ch, c;
      logic ok;
      logic [W-1:0] cd;
      ch = route ? p : 1 - p;
      c = n - (LAT - 1);
      ok = (c >= 0);
      if (ok) for (int k = c; k <= n; k++) if (hp[ch][k]) ok = 1'b0;
      e.d[p] = '0; e.o[p] = 1'b0; e.v[p] = 1'b0;
      if (oe[p]) e.tag[p] = "R6";
      else if (!ok) e.tag[p] = "R7";
      else begin
        cd = hc[ch][c];
        if (ho[ch][c]) cd = {W{cd[W-1]}};
        if (fmt) cd[W-1] = ~cd[W-1];
        e.d[p] = cd; e.o[p] = ho[ch][c]; e.v[p] = 1'b1;
        if (ho[ch][c]) e.tag[p] = "R5";
        else if (inter) e.tag[p] = "R4";
        else if (fmt) e.tag[p] = "R2";
        else if (!route) e.tag[p] = "R3";
        else e.tag[p] = "R1";
      end
    end
    q.push_back(e);
    n++;
  endtask

  task automatic plain(input int cnt, input logic fmt, input logic route, input int otr_mod);
    for (int i = 0; i < cnt; i++)
      step(W'($urandom), (otr_mod != 0) && ($urandom % otr_mod == 0),
           W'($urandom), (otr_mod != 0) && ($urandom % otr_mod == 0),
           1'b0, 1'b0, fmt, route, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pa_data !== '0 || pa_otr !== 1'b0 || pa_vld !== 1'b0 ||
        pb_data !== '0 || pb_otr !== 1'b0 || pb_vld !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset state: got A=%h/%b/%b B=%h/%b/%b expected all zero",
               pa_data, pa_otr, pa_vld, pb_data, pb_otr, pb_vld);
    end
    // R1: straight, offset binary, no over-range
    plain(20, 1'b0, 1'b1, 0);
    // R2: two's complement
    plain(20, 1'b1, 1'b1, 0);
    // R3: crossed steering
    plain(15, 1'b0, 1'b0, 0);
    // R4: steering toggled each cycle
    for (int i = 0; i < 20; i++)
      step(W'($urandom), 1'b0, W'($urandom), 1'b0, 1'b0, 1'b0, i[0], i[0] ? 1'b0 : 1'b1,
           1'b0, 1'b0, 1'b1);
    // R5: explicit high and low over-range in both formats, then random
    step(10'h3F0, 1'b1, 10'h010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(10'h010, 1'b1, 10'h3F0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    plain(10, 1'b0, 1'b1, 3);
    plain(10, 1'b1, 1'b0, 3);
    // R6: output enables
    for (int i = 0; i < 8; i++)
      step(W'($urandom), 1'b0, W'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
           i[0], ~i[0] & i[1], 1'b0);
    // R7: power-down of A, then refill
    for (int i = 0; i < 3; i++)
      step(W'($urandom), 1'b0, W'($urandom), 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    plain(10, 1'b0, 1'b1, 0);
    // R7: power-down of B while crossed
    for (int i = 0; i < 2; i++)
      step(W'($urandom), 1'b0, W'($urandom), 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    plain(10, 1'b1, 1'b0, 0);
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule